// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block takes a freshly reset SDRAM device from power-on to a ready state. After reset it keeps the clock-enable and all byte-mask lines high and drives only no-operation commands for a start-up interval. The interval is derived from the clock frequency and a hold time in microseconds. The block then closes both banks with one precharge, runs a programmable number of auto-refresh cycles, and loads the mode register. The mode word carries the chosen CAS latency, burst length and burst ordering. A fixed clock count separates each command from the next. Between commands, no-operations fill the gap.

The relative order of the refresh group and the mode load is a build option. Either order reaches the same end state. Once the last wait has elapsed, `init_done` rises and stays high. The command pins then rest at no-operation so that a memory controller can take over. Every timing value and every mode field is a parameter. Illegal settings stop elaboration.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high, and for the first STARTUP_CYC = CLK_MHZ*STARTUP_US clock cycles after it falls, the outputs hold a no-operation command {cs_n,ras_n,cas_n,we_n}=0111 with address and bank zero, clock enable 1, every mask bit 1 and `init_done` 0.
- R2: On the STARTUP_CYC-th rising edge after reset falls, a precharge command 0010 appears for exactly one cycle, with address bit AP_BIT (bit 10) set, all other address bits zero and bank zero.
- R3: The command that follows the precharge appears exactly T_RP_CLK cycles after it.
- R4: Exactly REFRESH_CNT auto-refresh commands 0001 are issued, with address and bank zero, each starting T_RC_CLK cycles after the previous refresh.
- R5: The mode-register load is a single command 0000 with bank zero, whose address carries the mode word; bits above bit 6 are zero.
- R6: Mode address bits 2..0 encode the burst length: 1 gives 000, 2 gives 001, 4 gives 010, 8 gives 011, and full page (BURST_LEN=256) gives 111.
- R7: Mode address bit 3 is 1 for interleaved bursts and 0 for sequential ones, and bits 6..4 hold the CAS latency in binary (2 gives 010, 3 gives 011).
- R8: With MRS_FIRST=0 the mode load follows the last refresh by T_RC_CLK cycles. With MRS_FIRST=1 the mode load comes T_RP_CLK cycles after the precharge, and the first refresh follows it.
- R9: No command other than a no-operation is driven during the T_MRD_CLK-1 cycles after the mode load.
- R10: `init_done` rises exactly T_MRD_CLK cycles after the mode load (MRS_FIRST=0) or T_RC_CLK cycles after the last refresh (MRS_FIRST=1). It then stays high while the command pins hold no-operation, with clock enable and masks high.
- R11: Every cycle between the commands above is a no-operation with address and bank zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the memory |
| rst | input | 1 | Synchronous reset, active high |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins; bit AP_BIT selects all banks on precharge |
| sd_ba | output | BANK_W | Bank select |
| sd_dqm | output | DQM_W | Byte masks |
| init_done | output | 1 | High once the start-up sequence has finished |

## Verification
The only stimulus is the fall of reset. From it, the bench computes the rising edge on which each command is due. The precharge is due on edge STARTUP_CYC. After it, each command is spaced by T_RP_CLK, T_RC_CLK or T_MRD_CLK, depending on the command before it. The outputs decode the sequencer state directly with no extra register stage, so each result is visible in the same cycle as the state change. The bench therefore compares every pin on the falling edge after the edge on which it is due. Two instances are checked cycle by cycle: one uses refresh-first ordering with a sequential, length-8, latency-3 mode, and the other uses mode-first ordering with an interleaved, full-page, latency-2 mode. Every cycle without a scheduled command must show a no-operation.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // command pins in the order {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR  = 4'b0000,
      CMD_AREF = 4'b0001,
      CMD_PCHG = 4'b0010,
      CMD_IDLE = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_POWER,
      ST_PCHG,
      ST_PCHG_W,
      ST_AREF,
      ST_AREF_W,
      ST_LMR,
      ST_LMR_W,
      ST_DONE
   } init_step_e;

   function automatic logic [2:0] burst_code(input int len);
      case (len)
         1:       return 3'b000;
         2:       return 3'b001;
         4:       return 3'b010;
         8:       return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

   function automatic logic [11:0] mode_word(input int cas_lat, input int len,
                                             input bit interleave);
      logic [11:0] w;
      w        = '0;
      w[2:0]   = burst_code(len);
      w[3]     = interleave;
      w[6:4]   = 3'(cas_lat);
      return w;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int TMR_W    = 8,
   parameter int INIT_VAL = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             zero
);

   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= TMR_W'(INIT_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - TMR_W'(1);
   end

   assign zero = (cnt == '0);

   // free-running countdown keeps the step spacing exact (R3)
   assert_timer_step_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - TMR_W'(1)));

   assert_timer_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt == '0) |=> zero);

endmodule

// File: rtl/sdram_init_steps.sv
module sdram_init_steps
   import sdram_init_pkg::*;
#(
   parameter int TMR_W       = 8,
   parameter int T_RP_CLK    = 2,
   parameter int T_RC_CLK    = 7,
   parameter int T_MRD_CLK   = 2,
   parameter int REFRESH_CNT = 2,
   parameter bit MRS_FIRST   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tmr_zero,
   output init_step_e       step,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   output logic             done
);

   localparam int RC_W = $clog2(REFRESH_CNT + 1);

   init_step_e        nxt;
   init_step_e        after_pchg, after_arefs, after_lmr;
   logic [RC_W-1:0]   aref_cnt;

   generate
      if (MRS_FIRST) begin : g_lmr_first
         assign after_pchg  = ST_LMR;
         assign after_lmr   = ST_AREF;
         assign after_arefs = ST_DONE;
      end else begin : g_aref_first
         assign after_pchg  = ST_AREF;
         assign after_arefs = ST_LMR;
         assign after_lmr   = ST_DONE;
      end
   endgenerate

   always_comb begin
      nxt      = step;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (step)
         ST_POWER:  if (tmr_zero) nxt = ST_PCHG;
         ST_PCHG: begin
            nxt      = ST_PCHG_W;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_RP_CLK - 2);
         end
         ST_PCHG_W: if (tmr_zero) nxt = after_pchg;
         ST_AREF: begin
            nxt      = ST_AREF_W;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_RC_CLK - 2);
         end
         ST_AREF_W:
            if (tmr_zero)
               nxt = (aref_cnt == RC_W'(REFRESH_CNT)) ? after_arefs : ST_AREF;
         ST_LMR: begin
            nxt      = ST_LMR_W;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_MRD_CLK - 2);
         end
         ST_LMR_W:  if (tmr_zero) nxt = after_lmr;
         default:   nxt = ST_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step     <= ST_POWER;
         aref_cnt <= '0;
      end else begin
         step <= nxt;
         if (step == ST_AREF)
            aref_cnt <= aref_cnt + RC_W'(1);
      end
   end

   assign done = (step == ST_DONE);

   assert_aref_bound_R4: assert property (@(posedge clk) disable iff (rst)
      aref_cnt <= RC_W'(REFRESH_CNT));

   assert_aref_all_R4: assert property (@(posedge clk) disable iff (rst)
      done |-> (aref_cnt == RC_W'(REFRESH_CNT)));

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   assert_pchg_single_R2: assert property (@(posedge clk) disable iff (rst)
      (step == ST_PCHG) |=> (step == ST_PCHG_W));

endmodule

// File: rtl/sdram_init_cmd.sv
module sdram_init_cmd
   import sdram_init_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                BANK_W    = 1,
   parameter int                AP_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
   input  init_step_e        step,
   output sd_cmd_e           cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba
);

   always_comb begin
      cmd  = CMD_IDLE;
      addr = '0;
      ba   = '0;
      case (step)
         ST_PCHG: begin
            cmd          = CMD_PCHG;
            addr[AP_BIT] = 1'b1;
         end
         ST_AREF: cmd = CMD_AREF;
         ST_LMR: begin
            cmd  = CMD_LMR;
            addr = MODE_WORD;
         end
         default: cmd = CMD_IDLE;
      endcase
   end

   always_comb begin
      assert_pchg_ap_R2: assert (cmd != CMD_PCHG || addr[AP_BIT]);
      assert_lmr_bank_R5: assert (cmd != CMD_LMR || ba == '0);
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int CLK_MHZ          = 100,
   parameter int STARTUP_US       = 200,
   parameter int T_RP_CLK         = 2,
   parameter int T_RC_CLK         = 7,
   parameter int T_MRD_CLK        = 2,
   parameter int REFRESH_CNT      = 2,
   parameter int CAS_LAT          = 3,
   parameter int BURST_LEN        = 8,
   parameter bit BURST_INTERLEAVE = 1'b0,
   parameter bit MRS_FIRST        = 1'b0,
   parameter int ADDR_W           = 12,
   parameter int BANK_W           = 1,
   parameter int DQM_W            = 2,
   parameter int AP_BIT           = 10
) (
   input  logic              clk,
   input  logic              rst,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_ba,
   output logic [DQM_W-1:0]  sd_dqm,
   output logic              init_done
);

   localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;
   localparam int WAIT_MAX    = (T_RC_CLK > T_RP_CLK) ?
                                ((T_RC_CLK > T_MRD_CLK) ? T_RC_CLK : T_MRD_CLK) :
                                ((T_RP_CLK > T_MRD_CLK) ? T_RP_CLK : T_MRD_CLK);
   localparam int CNT_MAX     = (STARTUP_CYC > WAIT_MAX) ? STARTUP_CYC : WAIT_MAX;
   localparam int TMR_W       = $clog2(CNT_MAX + 1);
   localparam logic [ADDR_W-1:0] MODE_WORD =
      ADDR_W'(mode_word(CAS_LAT, BURST_LEN, BURST_INTERLEAVE));

   // elaboration-time parameter checks
   generate
      if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
         $error("CAS_LAT must be 2 or 3");
      end
      if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 &&
          BURST_LEN != 8 && BURST_LEN != 256) begin : g_bad_bl
         $error("BURST_LEN must be 1, 2, 4, 8 or 256");
      end
      if (T_RP_CLK < 2 || T_RC_CLK < 2 || T_MRD_CLK < 2) begin : g_bad_wait
         $error("step spacings must be at least 2 clocks");
      end
      if (REFRESH_CNT < 2) begin : g_bad_ref
         $error("REFRESH_CNT must be at least 2");
      end
      if (STARTUP_CYC < 1) begin : g_bad_start
         $error("start-up interval must be at least one clock");
      end
      if (ADDR_W < 11 || AP_BIT < 7 || AP_BIT >= ADDR_W) begin : g_bad_addr
         $error("address width or all-bank bit out of range");
      end
   endgenerate

   init_step_e       step;
   sd_cmd_e          cmd;
   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;

   sdram_init_timer #(
      .TMR_W    (TMR_W),
      .INIT_VAL (STARTUP_CYC - 1)
   ) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdram_init_steps #(
      .TMR_W       (TMR_W),
      .T_RP_CLK    (T_RP_CLK),
      .T_RC_CLK    (T_RC_CLK),
      .T_MRD_CLK   (T_MRD_CLK),
      .REFRESH_CNT (REFRESH_CNT),
      .MRS_FIRST   (MRS_FIRST)
   ) steps_i (
      .clk      (clk),
      .rst      (rst),
      .tmr_zero (tmr_zero),
      .step     (step),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .done     (init_done)
   );

   sdram_init_cmd #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .AP_BIT    (AP_BIT),
      .MODE_WORD (MODE_WORD)
   ) cmd_i (
      .step (step),
      .cmd  (cmd),
      .addr (sd_addr),
      .ba   (sd_ba)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_cke = 1'b1;
   assign sd_dqm = '1;

   assert_lmr_gap_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(cmd) == CMD_LMR) |-> (cmd == CMD_IDLE));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
      init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

   assert_cmd_single_R11: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_IDLE) |=> (cmd == CMD_IDLE));

   assert_start_idle_R1: assert property (@(posedge clk) disable iff (rst)
      (step == ST_POWER) |-> (cmd == CMD_IDLE && !init_done));

endmodule

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RUN_CYC    = 80;

   // instance A: refresh first, sequential, length 8, latency 3
   localparam int A_START = 1 * 20;
   localparam int A_RP = 3, A_RC = 7, A_MRD = 2, A_N = 2;
   // instance B: mode load first, interleaved, full page, latency 2
   localparam int B_START = 3 * 8;
   localparam int B_RP = 2, B_RC = 4, B_MRD = 3, B_N = 3;

   typedef struct {
      int          cyc;
      logic [3:0]  cmd;
      logic [11:0] addr;
      string       tag;
   } exp_t;

   exp_t q_a[$];
   exp_t q_b[$];
   int   done_a, done_b;
   int   vectors  = 0;
   int   miscmp   = 0;
   bit   finished = 0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
   logic [11:0] a_addr;
   logic [0:0]  a_ba;
   logic [1:0]  a_dqm;
   logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
   logic [11:0] b_addr;
   logic [0:0]  b_ba;
   logic [1:0]  b_dqm;

   sdram_pwrup_seq #(
      .CLK_MHZ (1), .STARTUP_US (20),
      .T_RP_CLK (A_RP), .T_RC_CLK (A_RC), .T_MRD_CLK (A_MRD),
      .REFRESH_CNT (A_N), .CAS_LAT (3), .BURST_LEN (8),
      .BURST_INTERLEAVE (1'b0), .MRS_FIRST (1'b0)
   ) dut_i (
      .clk (clk), .rst (rst), .sd_cke (a_cke), .sd_cs_n (a_cs),
      .sd_ras_n (a_ras), .sd_cas_n (a_cas), .sd_we_n (a_we),
      .sd_addr (a_addr), .sd_ba (a_ba), .sd_dqm (a_dqm), .init_done (a_done)
   );

   sdram_pwrup_seq #(
      .CLK_MHZ (3), .STARTUP_US (8),
      .T_RP_CLK (B_RP), .T_RC_CLK (B_RC), .T_MRD_CLK (B_MRD),
      .REFRESH_CNT (B_N), .CAS_LAT (2), .BURST_LEN (256),
      .BURST_INTERLEAVE (1'b1), .MRS_FIRST (1'b1)
   ) dut_alt_i (
      .clk (clk), .rst (rst), .sd_cke (b_cke), .sd_cs_n (b_cs),
      .sd_ras_n (b_ras), .sd_cas_n (b_cas), .sd_we_n (b_we),
      .sd_addr (b_addr), .sd_ba (b_ba), .sd_dqm (b_dqm), .init_done (b_done)
   );

   // R6 / R7 field layout, computed from the requirement text
   function automatic logic [11:0] exp_mode(int cl, int bl, bit il);
      logic [11:0] w = '0;
      case (bl)
         1: w[2:0] = 3'b000;
         2: w[2:0] = 3'b001;
         4: w[2:0] = 3'b010;
         8: w[2:0] = 3'b011;
         default: w[2:0] = 3'b111;
      endcase
      w[3]   = il;
      w[6:4] = 3'(cl);
      return w;
   endfunction

   // driver side: push every scheduled command with its due edge
   task automatic plan(ref exp_t q[$], output int done_at, input int s,
                       input int trp, input int trc, input int tmrd,
                       input int n, input bit mf, input logic [11:0] mode);
      int t;
      q.push_back('{s, 4'b0010, 12'h400, "R2 precharge-all"});
      t = s + trp;
      if (mf) begin
         q.push_back('{t, 4'b0000, mode, "R3/R5/R6/R7/R8 mode load"});
         t = t + tmrd;
      end
      for (int i = 0; i < n; i++) begin
         if (i == 0)
            q.push_back('{t, 4'b0001, 12'h000,
                          mf ? "R4/R8/R9 first refresh" : "R3/R4 first refresh"});
         else
            q.push_back('{t, 4'b0001, 12'h000, "R4 refresh spacing"});
         t = t + trc;
      end
      if (!mf) begin
         q.push_back('{t, 4'b0000, mode, "R5/R6/R7/R8 mode load"});
         t = t + tmrd;
      end
      done_at = t;
   endtask

   task automatic check_pins(input string who, input int cyc, ref exp_t q[$],
                             input int done_at, input int s,
                             input logic [3:0] cmd, input logic [11:0] addr,
                             input logic ba, input logic cke,
                             input logic [1:0] dqm, input logic done);
      logic [3:0]  e_cmd  = 4'b0111;
      logic [11:0] e_addr = '0;
      logic        e_done;
      string       tag;
      if (q.size() > 0 && q[0].cyc == cyc) begin
         e_cmd  = q[0].cmd;
         e_addr = q[0].addr;
         tag    = q[0].tag;
         void'(q.pop_front());
      end else if (cyc < s)
         tag = "R1 start-up hold";
      else if (cyc >= done_at)
         tag = "R10 idle after done";
      else
         tag = "R11 gap between steps";
      e_done = (cyc >= done_at);
      vectors++;
      if (cmd !== e_cmd || addr !== e_addr || ba !== 1'b0 || cke !== 1'b1 ||
          dqm !== 2'b11 || done !== e_done) begin
         miscmp++;
         $display("FAIL %s %s cyc %0d: got cmd=%b addr=%h ba=%b cke=%b dqm=%b done=%b expected cmd=%b addr=%h ba=0 cke=1 dqm=11 done=%b",
                  tag, who, cyc, cmd, addr, ba, cke, dqm, done, e_cmd, e_addr, e_done);
      end
   endtask

   // monitor: compares both instances on every falling edge after reset
   initial begin
      int cyc = 0;
      wait (rst == 1'b0);
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc <= RUN_CYC) begin
            check_pins("dut_i", cyc, q_a, done_a, A_START,
                       {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba[0], a_cke, a_dqm, a_done);
            check_pins("dut_alt_i", cyc, q_b, done_b, B_START,
                       {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba[0], b_cke, b_dqm, b_done);
         end
      end
   end

   initial begin
      plan(q_a, done_a, A_START, A_RP, A_RC, A_MRD, A_N, 1'b0, exp_mode(3, 8, 1'b0));
      plan(q_b, done_b, B_START, B_RP, B_RC, B_MRD, B_N, 1'b1, exp_mode(2, 256, 1'b1));
      repeat (3) @(negedge clk);
      // R1: reset state, cycle index 0 precedes every scheduled command
      check_pins("dut_i", 0, q_a, done_a, A_START,
                 {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba[0], a_cke, a_dqm, a_done);
      check_pins("dut_alt_i", 0, q_b, done_b, B_START,
                 {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba[0], b_cke, b_dqm, b_done);
      rst = 1'b0;
      repeat (RUN_CYC + 2) @(negedge clk);
      // R4: every scheduled command must have been seen
      vectors++;
      if (q_a.size() != 0 || q_b.size() != 0) begin
         miscmp++;
         $display("FAIL R4 commands left unmatched: got %0d/%0d expected 0/0",
                  q_a.size(), q_b.size());
      end
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         finished = 1;
         miscmp++;
         $display("FAIL R10 watchdog expired: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

endmodule